// File: doc/BRIEF.md
# Pipelined Command Sequence Checker

This block watches the host command stream of a flash controller and polices pipelined (cache) transfers. A setup command opens a pipelined transaction. It carries a start page address, an interleave way count and a page count. From then on, the only legal command is a data command. Each data command must target the next expected page address and have the same direction as the setup. The first data command must target the start address, and each one accepted moves the expected address up by one.

When the last page is accepted, the block pulses a completion output and returns to idle. Any other command while a transaction is open is a sequence violation. On a violation the block recovers on its own. It pulses an error, requests a core reset of the device, and clears its pipeline registers. It also hands the offending request back to be served as an ordinary access, in the direction of the broken transaction. A data command that arrives with no transaction open is reported as an unsupported command.

All outputs are registered and change one clock after the command is sampled. Timing and data movement on the flash side are handled elsewhere.

Top module: `pipe_seq_checker`

## Requirements
- R1: After reset, `pipe_busy`, `pipe_err`, `core_rst_req`, `fallback_valid`, `fallback_write`, `pipe_done`, `unsup_cmd` are 0 and `fallback_addr` is 0.
- R2: A setup command (`cmd_kind` = 2'b01) sampled while idle, with nonzero `cmd_ways` and nonzero `cmd_pages`, sets `pipe_busy` one cycle later. No pulse output is raised.
- R3: A setup command sampled while idle with `cmd_ways` = 0 or `cmd_pages` = 0 pulses `unsup_cmd` for one cycle, and `pipe_busy` stays 0.
- R4: While busy, a data command (`cmd_kind` = 2'b10) whose address equals the expected address and whose `cmd_write` equals the setup direction is accepted without any pulse. The expected address starts at the setup address and increases by one, modulo 2^ADDR_W, per accepted data command.
- R5: The data command that accepts the last page pulses `pipe_done` for one cycle and clears `pipe_busy` in the same cycle.
- R6: While busy, a data command with an address other than the expected one (wrong start address or out-of-order page) raises `pipe_err`, `core_rst_req` and `fallback_valid` together, each for one cycle.
- R7: While busy, a command of any kind other than data (normal 2'b00, setup 2'b01, maintenance 2'b11) raises the same three pulses as R6.
- R8: While busy, a data command whose direction differs from the setup direction raises the same three pulses as R6.
- R9: A violation clears all pipeline state: `pipe_busy` drops in the cycle of the error pulse, and a data command sent afterwards is reported as unsupported.
- R10: During the fallback pulse, `fallback_addr` carries the address of the command that broke the sequence and `fallback_write` carries the direction of the broken transaction. Both read 0 when `fallback_valid` is 0.
- R11: A data command sampled while idle pulses `unsup_cmd` only, with no error or reset request.
- R12: Pipelined writes (`cmd_write` = 1 at setup) are tracked and checked exactly as pipelined reads.
- R13: Normal and maintenance commands sampled while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_kind | input | 2 | 00 normal, 01 pipeline setup, 10 pipeline data, 11 maintenance |
| cmd_addr | input | ADDR_W | Page address of the command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ways | input | WAY_W | Interleave way count (setup only) |
| cmd_pages | input | PAGE_W | Page count (setup only) |
| pipe_busy | output | 1 | A pipelined transaction is open |
| pipe_err | output | 1 | One-cycle sequence violation pulse |
| core_rst_req | output | 1 | One-cycle device core reset request |
| fallback_valid | output | 1 | One-cycle request to serve an access as non-pipelined |
| fallback_addr | output | ADDR_W | Address of the fallback access |
| fallback_write | output | 1 | Direction of the fallback access |
| pipe_done | output | 1 | One-cycle transaction completion pulse |
| unsup_cmd | output | 1 | One-cycle unsupported command pulse |

## Verification
The assertions check several invariants on every cycle. An open transaction always has pages left, and an accepted page moves the expected address by exactly one. A violation leaves the tracker empty on the next cycle. The error, reset request and fallback pulses always appear together, never alongside a completion or unsupported pulse, and an idle fallback carries zeros. The bench scenarios show the rest: which command sequences count as legal, the start-address, ordering and direction violations, address wrap-around, the write path, and that state is truly flushed after a violation.

// File: rtl/pipe_seq_pkg.sv
package pipe_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NORMAL = 2'b00,
    CMD_SETUP  = 2'b01,
    CMD_DATA   = 2'b10,
    CMD_MAINT  = 2'b11
  } cmd_kind_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_OPEN,
    EV_ADVANCE,
    EV_FINISH,
    EV_VIOLATE,
    EV_UNSUP
  } seq_event_e;

endpackage

// File: rtl/pipe_seq_rst_sync.sv
module pipe_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pipe_seq_decode.sv
module pipe_seq_decode
  import pipe_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAY_W  = 4,
  parameter int PAGE_W = 8
) (
  input  logic              cmd_valid,
  input  cmd_kind_e         cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [WAY_W-1:0]  cmd_ways,
  input  logic [PAGE_W-1:0] cmd_pages,
  input  logic              trk_active,
  input  logic [ADDR_W-1:0] trk_expect,
  input  logic              trk_dir,
  input  logic [PAGE_W-1:0] trk_left,
  output seq_event_e        event_o
);

  logic setup_ok;
  logic data_match;
  logic last_page;

  always_comb begin
    setup_ok   = (|cmd_ways) && (|cmd_pages);
    data_match = (cmd_kind == CMD_DATA) && (cmd_addr == trk_expect) && (cmd_write == trk_dir);
    last_page  = (trk_left == PAGE_W'(1));
    event_o    = EV_NONE;
    if (cmd_valid) begin
      if (!trk_active) begin
        unique case (cmd_kind)
          CMD_SETUP: event_o = setup_ok ? EV_OPEN : EV_UNSUP;
          CMD_DATA:  event_o = EV_UNSUP;
          default:   event_o = EV_NONE;
        endcase
      end else if (data_match) begin
        event_o = last_page ? EV_FINISH : EV_ADVANCE;
      end else begin
        event_o = EV_VIOLATE;
      end
    end
  end

endmodule

// File: rtl/pipe_seq_tracker.sv
module pipe_seq_tracker
  import pipe_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_event_e        event_i,
  input  logic [ADDR_W-1:0] open_addr,
  input  logic              open_dir,
  input  logic [PAGE_W-1:0] open_pages,
  output logic              active_o,
  output logic [ADDR_W-1:0] expect_o,
  output logic              dir_o,
  output logic [PAGE_W-1:0] left_o
);

  logic              active_q, active_d;
  logic [ADDR_W-1:0] expect_q, expect_d;
  logic              dir_q, dir_d;
  logic [PAGE_W-1:0] left_q, left_d;
  logic              state_en;

  always_comb begin
    state_en = (event_i != EV_NONE) && (event_i != EV_UNSUP);
    active_d = active_q;
    expect_d = expect_q;
    dir_d    = dir_q;
    left_d   = left_q;
    unique case (event_i)
      EV_OPEN: begin
        active_d = 1'b1;
        expect_d = open_addr;
        dir_d    = open_dir;
        left_d   = open_pages;
      end
      EV_ADVANCE: begin
        expect_d = expect_q + ADDR_W'(1);
        left_d   = left_q - PAGE_W'(1);
      end
      EV_FINISH, EV_VIOLATE: begin
        active_d = 1'b0;
        expect_d = '0;
        dir_d    = 1'b0;
        left_d   = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      expect_q <= '0;
      dir_q    <= 1'b0;
      left_q   <= '0;
    end else if (state_en) begin
      active_q <= active_d;
      expect_q <= expect_d;
      dir_q    <= dir_d;
      left_q   <= left_d;
    end
  end

  assign active_o = active_q;
  assign expect_o = expect_q;
  assign dir_o    = dir_q;
  assign left_o   = left_q;

  // R5: an open transaction always has pages outstanding
  p_pages_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (left_q != '0));

  // R4: an accepted page moves the expected address by exactly one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i == EV_ADVANCE) |=> (expect_q == $past(expect_q) + ADDR_W'(1)));

  // R9: a violation flushes every pipeline register
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i == EV_VIOLATE) |=> (!active_q && expect_q == '0 && left_q == '0 && !dir_q));

endmodule

// File: rtl/pipe_seq_resp.sv
module pipe_seq_resp
  import pipe_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_event_e        event_i,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              trk_dir,
  output logic              err_o,
  output logic              rst_req_o,
  output logic              fb_valid_o,
  output logic [ADDR_W-1:0] fb_addr_o,
  output logic              fb_write_o,
  output logic              done_o,
  output logic              unsup_o
);

  logic              err_q, err_d;
  logic              rreq_q, rreq_d;
  logic              fbv_q, fbv_d;
  logic [ADDR_W-1:0] fba_q, fba_d;
  logic              fbw_q, fbw_d;
  logic              done_q, done_d;
  logic              unsup_q, unsup_d;

  always_comb begin
    err_d   = (event_i == EV_VIOLATE);
    rreq_d  = (event_i == EV_VIOLATE);
    fbv_d   = (event_i == EV_VIOLATE);
    fba_d   = (event_i == EV_VIOLATE) ? cmd_addr : '0;
    fbw_d   = (event_i == EV_VIOLATE) ? trk_dir  : 1'b0;
    done_d  = (event_i == EV_FINISH);
    unsup_d = (event_i == EV_UNSUP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      rreq_q  <= 1'b0;
      fbv_q   <= 1'b0;
      fba_q   <= '0;
      fbw_q   <= 1'b0;
      done_q  <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      err_q   <= err_d;
      rreq_q  <= rreq_d;
      fbv_q   <= fbv_d;
      fba_q   <= fba_d;
      fbw_q   <= fbw_d;
      done_q  <= done_d;
      unsup_q <= unsup_d;
    end
  end

  assign err_o      = err_q;
  assign rst_req_o  = rreq_q;
  assign fb_valid_o = fbv_q;
  assign fb_addr_o  = fba_q;
  assign fb_write_o = fbw_q;
  assign done_o     = done_q;
  assign unsup_o    = unsup_q;

  // R6: error, core reset request and fallback always travel together
  p_recovery_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (rreq_q && fbv_q));

  // R11: at most one kind of event is reported per cycle
  p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_q, done_q, unsup_q}));

  // R10: fallback fields are zero when no fallback is offered
  p_fb_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fbv_q |-> (fba_q == '0 && !fbw_q));

  // R6: pulses last a single cycle unless a new violation arrives
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && event_i != EV_VIOLATE) |=> !err_q);

endmodule

// File: rtl/pipe_seq_checker.sv
module pipe_seq_checker
  import pipe_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAY_W  = 4,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [WAY_W-1:0]  cmd_ways,
  input  logic [PAGE_W-1:0] cmd_pages,
  output logic              pipe_busy,
  output logic              pipe_err,
  output logic              core_rst_req,
  output logic              fallback_valid,
  output logic [ADDR_W-1:0] fallback_addr,
  output logic              fallback_write,
  output logic              pipe_done,
  output logic              unsup_cmd
);

  logic              rst_sync_n;
  seq_event_e        seq_event;
  logic              trk_active;
  logic [ADDR_W-1:0] trk_expect;
  logic              trk_dir;
  logic [PAGE_W-1:0] trk_left;

  pipe_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pipe_seq_decode #(.ADDR_W(ADDR_W), .WAY_W(WAY_W), .PAGE_W(PAGE_W)) u_dec (
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind_e'(cmd_kind)),
    .cmd_addr   (cmd_addr),
    .cmd_write  (cmd_write),
    .cmd_ways   (cmd_ways),
    .cmd_pages  (cmd_pages),
    .trk_active (trk_active),
    .trk_expect (trk_expect),
    .trk_dir    (trk_dir),
    .trk_left   (trk_left),
    .event_o    (seq_event)
  );

  pipe_seq_tracker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .event_i    (seq_event),
    .open_addr  (cmd_addr),
    .open_dir   (cmd_write),
    .open_pages (cmd_pages),
    .active_o   (trk_active),
    .expect_o   (trk_expect),
    .dir_o      (trk_dir),
    .left_o     (trk_left)
  );

  pipe_seq_resp #(.ADDR_W(ADDR_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .event_i    (seq_event),
    .cmd_addr   (cmd_addr),
    .trk_dir    (trk_dir),
    .err_o      (pipe_err),
    .rst_req_o  (core_rst_req),
    .fb_valid_o (fallback_valid),
    .fb_addr_o  (fallback_addr),
    .fb_write_o (fallback_write),
    .done_o     (pipe_done),
    .unsup_o    (unsup_cmd)
  );

  assign pipe_busy = trk_active;

  // R9: the cycle that reports a violation shows the transaction closed
  p_err_closes_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pipe_err |-> !pipe_busy);

  // R5: completion closes the transaction
  p_done_closes_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pipe_done |-> !pipe_busy);

endmodule

// File: tb/pipe_seq_checker_test.sv
module pipe_seq_checker_test;

  localparam int AW = 16;
  localparam int WW = 4;
  localparam int PW = 8;
  localparam int VW = AW + 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_kind = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [WW-1:0] cmd_ways = '0;
  logic [PW-1:0] cmd_pages = '0;
  logic          pipe_busy, pipe_err, core_rst_req, fallback_valid;
  logic [AW-1:0] fallback_addr;
  logic          fallback_write, pipe_done, unsup_cmd;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  // bench-side model state, derived from the requirements
  bit            m_act = 1'b0;
  logic [AW-1:0] m_exp = '0;
  bit            m_dir = 1'b0;
  int            m_left = 0;

  always #10 clk = ~clk;

  pipe_seq_checker #(.ADDR_W(AW), .WAY_W(WW), .PAGE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_ways(cmd_ways),
    .cmd_pages(cmd_pages), .pipe_busy(pipe_busy), .pipe_err(pipe_err),
    .core_rst_req(core_rst_req), .fallback_valid(fallback_valid),
    .fallback_addr(fallback_addr), .fallback_write(fallback_write),
    .pipe_done(pipe_done), .unsup_cmd(unsup_cmd)
  );

  function automatic logic [VW-1:0] pack_out(bit busy, bit err, bit rr, bit fv,
                                             bit fw, bit dn, bit us, logic [AW-1:0] fa);
    return {busy, err, rr, fv, fw, dn, us, fa};
  endfunction

  // driver: applies one cycle of stimulus and queues the expected response
  task automatic drive(bit v, logic [1:0] k, logic [AW-1:0] a, bit w,
                       int ways, int pages, string tag);
    bit err = 0, dn = 0, us = 0, fw = 0;
    logic [AW-1:0] fa = '0;
    @(negedge clk);
    cmd_valid = v; cmd_kind = k; cmd_addr = a; cmd_write = w;
    cmd_ways = WW'(ways); cmd_pages = PW'(pages);
    if (v) begin
      if (!m_act) begin
        if (k == 2'b01) begin
          if (ways != 0 && pages != 0) begin
            m_act = 1; m_exp = a; m_dir = w; m_left = pages;
          end else us = 1;
        end else if (k == 2'b10) us = 1;
      end else if (k == 2'b10 && a == m_exp && w == m_dir) begin
        if (m_left == 1) begin
          dn = 1; m_act = 0; m_exp = '0; m_dir = 0; m_left = 0;
        end else begin
          m_exp = m_exp + 1'b1; m_left--;
        end
      end else begin
        err = 1; fa = a; fw = m_dir;
        m_act = 0; m_exp = '0; m_dir = 0; m_left = 0;
      end
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    exp_q.push_back(pack_out(m_act, err, err, err, fw, dn, us, fa));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(0, 2'b00, '0, 0, 0, 0, tag);
  endtask

  // monitor: compares design outputs with the queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [VW-1:0] act_v, exp_v;
      string t;
      exp_v = exp_q.pop_front();
      t = tag_q.pop_front();
      act_v = pack_out(pipe_busy, pipe_err, core_rst_req, fallback_valid,
                       fallback_write, pipe_done, unsup_cmd, fallback_addr);
      checks++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s: got busy/err/rst/fbv/fbw/done/unsup/addr=%b/%h expected %b/%h",
                 t, act_v[VW-1:AW], act_v[AW-1:0], exp_v[VW-1:AW], exp_v[AW-1:0]);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({pipe_busy, pipe_err, core_rst_req, fallback_valid, fallback_write,
         pipe_done, unsup_cmd} !== 7'b0 || fallback_addr !== '0) begin
      fails++;
      $display("FAIL R1: got outputs %b addr %h expected 0", {pipe_busy, pipe_err,
               core_rst_req, fallback_valid, fallback_write, pipe_done, unsup_cmd}, fallback_addr);
    end

    // R13: normal and maintenance commands while idle
    drive(1, 2'b00, 16'h0040, 0, 0, 0, "R13 normal idle");
    drive(1, 2'b11, 16'h0041, 1, 0, 0, "R13 maint idle");
    // R11: data command with nothing open
    drive(1, 2'b10, 16'h0050, 0, 0, 0, "R11 data idle");
    idle(1, "R11 quiet");
    // R3: malformed setup
    drive(1, 2'b01, 16'h0060, 0, 8, 0, "R3 zero pages");
    drive(1, 2'b01, 16'h0060, 0, 0, 4, "R3 zero ways");
    // R2 / R4 / R5: read pipeline of three pages
    drive(1, 2'b01, 16'h0100, 0, 8, 3, "R2 open read");
    drive(1, 2'b10, 16'h0100, 0, 0, 0, "R4 page 0");
    idle(1, "R4 hold");
    drive(1, 2'b10, 16'h0101, 0, 0, 0, "R4 page 1");
    drive(1, 2'b10, 16'h0102, 0, 0, 0, "R5 last page");
    idle(1, "R5 idle after");
    // R12: write pipeline
    drive(1, 2'b01, 16'h0A00, 1, 4, 2, "R12 open write");
    drive(1, 2'b10, 16'h0A00, 1, 0, 0, "R12 page 0");
    drive(1, 2'b10, 16'h0A01, 1, 0, 0, "R12 last page");
    // R6 / R10 / R9: wrong start address, then flushed state
    drive(1, 2'b01, 16'h0200, 0, 8, 10, "R2 open ten");
    drive(1, 2'b10, 16'h0201, 0, 0, 0, "R6 R10 wrong start");
    idle(1, "R6 single pulse");
    drive(1, 2'b10, 16'h0200, 0, 0, 0, "R9 flushed data unsup");
    // R6: out-of-order page
    drive(1, 2'b01, 16'h0300, 0, 2, 5, "R2 open five");
    drive(1, 2'b10, 16'h0300, 0, 0, 0, "R4 first");
    drive(1, 2'b10, 16'h0302, 0, 0, 0, "R6 skipped page");
    // R8: direction mismatch
    drive(1, 2'b01, 16'h0400, 0, 2, 3, "R2 open");
    drive(1, 2'b10, 16'h0400, 1, 0, 0, "R8 wrong direction");
    // R7 / R10 / R12: normal command breaks a write pipeline
    drive(1, 2'b01, 16'h0500, 1, 8, 4, "R12 open write");
    drive(1, 2'b10, 16'h0500, 1, 0, 0, "R12 page 0");
    drive(1, 2'b00, 16'h0777, 0, 0, 0, "R7 R10 normal mid-pipe");
    // R7: second setup and maintenance command mid-pipe
    drive(1, 2'b01, 16'h0600, 0, 8, 4, "R2 open");
    drive(1, 2'b01, 16'h0600, 0, 8, 4, "R7 setup mid-pipe");
    drive(1, 2'b01, 16'h0610, 1, 8, 4, "R2 open write");
    drive(1, 2'b11, 16'h0611, 0, 0, 0, "R7 maint mid-pipe");
    // R4: address wrap-around
    drive(1, 2'b01, 16'hFFFF, 0, 4, 2, "R2 open at top");
    drive(1, 2'b10, 16'hFFFF, 0, 0, 0, "R4 top page");
    drive(1, 2'b10, 16'h0000, 0, 0, 0, "R5 wrapped last");
    // R9: violation in a single-page transaction, then data unsupported
    drive(1, 2'b01, 16'h0800, 0, 1, 1, "R2 open one");
    drive(1, 2'b10, 16'h0801, 0, 0, 0, "R6 wrong single");
    drive(1, 2'b10, 16'h0801, 0, 0, 0, "R9 data unsup");
    idle(2, "R9 settle");
    @(negedge clk);
    finish_run();
  end

endmodule